// File: doc/BRIEF.md
# Serial 16-bit Command Receiver for a Multiplexed LED Display Controller

This block receives write-only commands over a three-wire serial link: an active-low select, a serial clock and a data line. All three wires are brought into the system clock domain through a two-flop synchroniser. Edges of the serial clock are found there, and the data bit is taken on each rising serial-clock edge while the select is low. Bits arrive most significant first. When the select returns high, the block checks whether at least sixteen bits were seen. If so, it splits the final sixteen into a register address (upper byte) and a data byte (lower byte).

The address is then decoded into one-cycle write strobes for the display controller's register file. There are five control strobes (per-digit font decode enable, brightness, number of scanned digits, configuration, lamp test) and two digit-plane strobes. A digit write names its digit in the low three address bits, so the data byte and digit index are presented together with the strobe. The idle address and the factory-reserved address produce nothing, and so does any address not in the map.

A host reaches a device at the end of a chain of shift-register devices by clocking out a longer stream. Only the last sixteen bits count, so commands meant for devices further up the chain can be matched with an idle command for this one.

Top module: `serial_cmd_rx`

## Requirements
- R1: Bits are taken MSB first. Of the 16 bits kept, bits 15..8 form the address and bits 7..0 form `wr_data`.
- R2: When more than 16 bits arrive during one select-low period, only the final 16 bits are used.
- R3: A frame with fewer than 16 bits at the select rise is discarded. The bit count restarts on every select fall, so two short frames never combine.
- R4: A command takes effect only after the select rises. Each accepted command gives exactly one strobe pulse, one system clock wide.
- R5: The control strobes map as follows: address 0x01 drives `wr_decode`, 0x02 drives `wr_bright`, 0x03 drives `wr_scan`, 0x04 drives `wr_cfg` and 0x07 drives `wr_test`.
- R6: The digit-plane writes map as follows. Addresses 0x20..0x27 drive `wr_plane0` only, 0x40..0x47 drive `wr_plane1` only, and 0x60..0x67 drive both. `wr_digit` equals the low three address bits and is held between writes.
- R7: Address 0x00 (idle) and address 0x06 (reserved) raise no strobe, and `wr_data` keeps its previous value.
- R8: Every address outside the map (for example 0x05, 0x28, 0x80) raises no strobe.
- R9: At most one control strobe is high in any cycle, and a control strobe never coincides with a plane strobe.
- R10: After reset all strobes are low and `wr_data` and `wr_digit` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_cs_n | input | 1 | Serial select, active low, asynchronous |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_din | input | 1 | Serial data, asynchronous |
| wr_decode | output | 1 | Write pulse, font decode enable register |
| wr_bright | output | 1 | Write pulse, brightness register |
| wr_scan | output | 1 | Write pulse, scanned-digit count register |
| wr_cfg | output | 1 | Write pulse, configuration register |
| wr_test | output | 1 | Write pulse, lamp test register |
| wr_plane0 | output | 1 | Write pulse, digit plane 0 |
| wr_plane1 | output | 1 | Write pulse, digit plane 1 |
| wr_digit | output | 3 | Digit index of the last plane write |
| wr_data | output | 8 | Data byte of the last accepted write |

## Verification
The assertions check three things on every cycle. Strobes are mutually exclusive and last one cycle. A strobe only follows a select seen high three cycles earlier. The data byte and digit index change only together with a strobe. Reset silences all outputs. Only the bench scenarios can show that the right strobe fires for a given address and that bit order is kept. They also show that the final sixteen of a long stream win, and that short, idle, reserved and unmapped frames leave the outputs untouched.

// File: rtl/serial_cmd_pkg.sv
// Shared constants, strobe type and address decoder for the serial command
// receiver. Assumes an 8-bit address and 8-bit data frame.
package serial_cmd_pkg;
    localparam int FRAME_W  = 16;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int DIGIT_W  = 3;

    localparam logic [ADDR_W-1:0] A_IDLE   = 8'h00;
    localparam logic [ADDR_W-1:0] A_DECODE = 8'h01;
    localparam logic [ADDR_W-1:0] A_BRIGHT = 8'h02;
    localparam logic [ADDR_W-1:0] A_SCAN   = 8'h03;
    localparam logic [ADDR_W-1:0] A_CFG    = 8'h04;
    localparam logic [ADDR_W-1:0] A_RSVD   = 8'h06;
    localparam logic [ADDR_W-1:0] A_TEST   = 8'h07;

    // Upper address bits that select a digit-plane group
    localparam logic [ADDR_W-DIGIT_W-1:0] G_PLANE0 = 5'b00100;
    localparam logic [ADDR_W-DIGIT_W-1:0] G_PLANE1 = 5'b01000;
    localparam logic [ADDR_W-DIGIT_W-1:0] G_BOTH   = 5'b01100;

    typedef struct packed {
        logic decode;
        logic bright;
        logic scan;
        logic cfg;
        logic test;
        logic plane0;
        logic plane1;
    } wr_strobe_t;

    // Map an address to its strobe set; unmapped, idle and reserved give none
    function automatic wr_strobe_t decode_addr(input logic [ADDR_W-1:0] a);
        wr_strobe_t s;
        s = '0;
        case (a)
            A_DECODE: s.decode = 1'b1;
            A_BRIGHT: s.bright = 1'b1;
            A_SCAN:   s.scan   = 1'b1;
            A_CFG:    s.cfg    = 1'b1;
            A_TEST:   s.test   = 1'b1;
            default: begin
                case (a[ADDR_W-1:DIGIT_W])
                    G_PLANE0: s.plane0 = 1'b1;
                    G_PLANE1: s.plane1 = 1'b1;
                    G_BOTH: begin
                        s.plane0 = 1'b1;
                        s.plane1 = 1'b1;
                    end
                    default: s = '0;
                endcase
            end
        endcase
        return s;
    endfunction
endpackage

// File: rtl/serial_edge_sync.sv
// Two-flop synchroniser with edge detection for a vector of asynchronous
// inputs. Assumes each input holds at least three system clocks per level.
module serial_edge_sync #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] stage1, stage2, stage3;

    // Synchronising chain plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
            stage3 <= RST_VAL;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
            stage3 <= stage2;
        end
    end

    // Level and edge outputs per bit
    always_comb begin
        level = stage2;
        rise  = stage2 & ~stage3;
        fall  = ~stage2 & stage3;
    end
endmodule

// File: rtl/serial_frame_shift.sv
// Shift register that keeps the newest FRAME_W bits, MSB first, and counts
// received bits up to FRAME_W. The count restarts on each select fall.
module serial_frame_shift #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_low,
    input  logic               sel_fall,
    input  logic               bit_strobe,
    input  logic               bit_val,
    output logic [FRAME_W-1:0] frame,
    output logic               full
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    logic [CNT_W-1:0] cnt, cnt_base, cnt_next;
    logic             take;

    // Next bit count: restart on select fall, saturate at a full frame
    always_comb begin
        take     = bit_strobe && sel_low;
        cnt_base = sel_fall ? '0 : cnt;
        cnt_next = cnt_base;
        if (take && cnt_base != CNT_FULL) begin
            cnt_next = cnt_base + 1'b1;
        end
    end

    // Shift register and counter state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '0;
            cnt   <= '0;
        end else begin
            cnt <= cnt_next;
            if (take) begin
                frame <= {frame[FRAME_W-2:0], bit_val};
            end
        end
    end

    assign full = (cnt == CNT_FULL);
endmodule

// File: rtl/serial_cmd_decode.sv
// Registers the decoded write strobes, data byte and digit index when a
// complete frame is closed by the select rise. Strobes last one cycle.
module serial_cmd_decode
    import serial_cmd_pkg::*;
#(
    parameter int FRAME_W = serial_cmd_pkg::FRAME_W,
    parameter int DATA_W  = serial_cmd_pkg::DATA_W,
    parameter int DIGIT_W = serial_cmd_pkg::DIGIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               close_evt,
    input  logic               full,
    input  logic [FRAME_W-1:0] frame,
    output wr_strobe_t         strobe,
    output logic [DATA_W-1:0]  data,
    output logic [DIGIT_W-1:0] digit
);
    localparam int ADDR_W = FRAME_W - DATA_W;

    logic [ADDR_W-1:0] addr;
    wr_strobe_t        dec;

    // Combinational address decode of the held frame
    always_comb begin
        addr = frame[FRAME_W-1:DATA_W];
        dec  = decode_addr(addr);
    end

    // One-cycle strobes; data and index load only with a real write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= '0;
            data   <= '0;
            digit  <= '0;
        end else begin
            strobe <= '0;
            if (close_evt && full) begin
                strobe <= dec;
                if (dec != '0) begin
                    data <= frame[DATA_W-1:0];
                end
                if (dec.plane0 || dec.plane1) begin
                    digit <= addr[DIGIT_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/serial_cmd_rx.sv
// Top of the serial command receiver: synchronises the three serial wires,
// collects bits while select is low and decodes the final 16 bits on the
// select rise into register write strobes.
module serial_cmd_rx
    import serial_cmd_pkg::*;
#(
    parameter int FRAME_W = serial_cmd_pkg::FRAME_W,
    parameter int DATA_W  = serial_cmd_pkg::DATA_W,
    parameter int DIGIT_W = serial_cmd_pkg::DIGIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_cs_n,
    input  logic               ser_clk,
    input  logic               ser_din,
    output logic               wr_decode,
    output logic               wr_bright,
    output logic               wr_scan,
    output logic               wr_cfg,
    output logic               wr_test,
    output logic               wr_plane0,
    output logic               wr_plane1,
    output logic [DIGIT_W-1:0] wr_digit,
    output logic [DATA_W-1:0]  wr_data
);
    localparam int IDX_CS  = 2;
    localparam int IDX_CLK = 1;
    localparam int IDX_DIN = 0;

    logic [2:0]         lvl, rse, fll;
    logic [FRAME_W-1:0] frame;
    logic               full;
    wr_strobe_t         strobe;

    serial_edge_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_cs_n, ser_clk, ser_din}),
        .level    (lvl),
        .rise     (rse),
        .fall     (fll)
    );

    serial_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_low    (!lvl[IDX_CS]),
        .sel_fall   (fll[IDX_CS]),
        .bit_strobe (rse[IDX_CLK]),
        .bit_val    (lvl[IDX_DIN]),
        .frame      (frame),
        .full       (full)
    );

    serial_cmd_decode #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .close_evt (rse[IDX_CS]),
        .full      (full),
        .frame     (frame),
        .strobe    (strobe),
        .data      (wr_data),
        .digit     (wr_digit)
    );

    // Break the strobe record out onto the ports
    always_comb begin
        wr_decode = strobe.decode;
        wr_bright = strobe.bright;
        wr_scan   = strobe.scan;
        wr_cfg    = strobe.cfg;
        wr_test   = strobe.test;
        wr_plane0 = strobe.plane0;
        wr_plane1 = strobe.plane1;
    end
endmodule

// File: rtl/serial_cmd_rx_chk.sv
// Protocol checker for serial_cmd_rx, attached by bind.
module serial_cmd_rx_chk #(
    parameter int DATA_W  = 8,
    parameter int DIGIT_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ser_cs_n,
    input logic               wr_decode,
    input logic               wr_bright,
    input logic               wr_scan,
    input logic               wr_cfg,
    input logic               wr_test,
    input logic               wr_plane0,
    input logic               wr_plane1,
    input logic [DIGIT_W-1:0] wr_digit,
    input logic [DATA_W-1:0]  wr_data
);
    logic any_wr;
    assign any_wr = wr_decode | wr_bright | wr_scan | wr_cfg | wr_test | wr_plane0 | wr_plane1;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_decode, wr_bright, wr_scan, wr_cfg, wr_test, wr_plane0 | wr_plane1})); // R9
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr |=> !any_wr); // R4
    AST_AFTER_SEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr |-> $past(ser_cs_n, 3)); // R4
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |-> $stable(wr_data)); // R7
    AST_DIGIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_plane0 | wr_plane1) |-> $stable(wr_digit)); // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!any_wr && wr_data == '0 && wr_digit == '0)); // R10
endmodule

bind serial_cmd_rx serial_cmd_rx_chk #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_cs_n  (ser_cs_n),
    .wr_decode (wr_decode),
    .wr_bright (wr_bright),
    .wr_scan   (wr_scan),
    .wr_cfg    (wr_cfg),
    .wr_test   (wr_test),
    .wr_plane0 (wr_plane0),
    .wr_plane1 (wr_plane1),
    .wr_digit  (wr_digit),
    .wr_data   (wr_data)
);

// File: tb/serial_cmd_rx_bench.sv
// Directed bench for serial_cmd_rx: one task per scenario.
module serial_cmd_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       din = 1'b0;
    logic       wr_decode, wr_bright, wr_scan, wr_cfg, wr_test, wr_plane0, wr_plane1;
    logic [2:0] wr_digit;
    logic [7:0] wr_data;

    int total = 0;
    int bad = 0;
    int n_ev = 0;
    logic [6:0] last_mask = '0;
    logic [7:0] last_data = '0;
    logic [2:0] last_digit = '0;
    bit finished = 0;

    always #4 clk = ~clk;

    serial_cmd_rx u_serial_cmd_rx (
        .clk(clk), .rst_n(rst_n), .ser_cs_n(cs_n), .ser_clk(sclk), .ser_din(din),
        .wr_decode(wr_decode), .wr_bright(wr_bright), .wr_scan(wr_scan), .wr_cfg(wr_cfg),
        .wr_test(wr_test), .wr_plane0(wr_plane0), .wr_plane1(wr_plane1),
        .wr_digit(wr_digit), .wr_data(wr_data)
    );

    // Strobe mask order: decode, bright, scan, cfg, test, plane0, plane1
    wire [6:0] mask_now = {wr_decode, wr_bright, wr_scan, wr_cfg, wr_test, wr_plane0, wr_plane1};

    // Log every strobe cycle away from the active edge
    always @(negedge clk) begin
        if (mask_now != '0) begin
            n_ev++;
            last_mask  = mask_now;
            last_data  = wr_data;
            last_digit = wr_digit;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Send the low nbits of val, MSB first, within one select-low period
    task automatic send_frame(input int nbits, input logic [31:0] val);
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            din = val[i];
            repeat (3) @(negedge clk);
            sclk = 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    // Send one frame and compare the resulting strobe activity
    task automatic run_case(input string tag, input int nbits, input logic [31:0] val,
                            input logic [6:0] exp_mask, input logic [7:0] exp_data,
                            input logic [2:0] exp_digit);
        int base;
        base = n_ev;
        send_frame(nbits, val);
        if (exp_mask == '0) begin
            chk(n_ev == base, {tag, " no strobe"}, n_ev - base, 0);
            chk(wr_data == exp_data, {tag, " data held"}, wr_data, exp_data);
        end else begin
            chk(n_ev == base + 1, {tag, " one pulse"}, n_ev - base, 1);
            chk(last_mask == exp_mask, {tag, " strobe"}, last_mask, exp_mask);
            chk(last_data == exp_data, {tag, " data"}, last_data, exp_data);
            if (exp_mask[1:0] != 2'b00)
                chk(last_digit == exp_digit, {tag, " digit"}, last_digit, exp_digit);
        end
    endtask

    task automatic t_reset();
        chk(mask_now == '0, "R10 strobes idle", mask_now, 0);
        chk(wr_data == '0, "R10 data zero", wr_data, 0);
        chk(wr_digit == '0, "R10 digit zero", wr_digit, 0);
    endtask

    task automatic t_control();
        run_case("R5 decode", 16, 32'h01C3, 7'b1000000, 8'hC3, 3'd0);
        run_case("R5 bright", 16, 32'h020F, 7'b0100000, 8'h0F, 3'd0);
        run_case("R1 R5 scan order", 16, 32'h03A5, 7'b0010000, 8'hA5, 3'd0);
        run_case("R5 cfg", 16, 32'h0481, 7'b0001000, 8'h81, 3'd0);
        run_case("R5 R9 test", 16, 32'h0701, 7'b0000100, 8'h01, 3'd0);
    endtask

    task automatic t_digit();
        run_case("R6 plane0 d3", 16, 32'h2305, 7'b0000010, 8'h05, 3'd3);
        run_case("R6 plane1 d7", 16, 32'h47FF, 7'b0000001, 8'hFF, 3'd7);
        run_case("R6 both d1", 16, 32'h6142, 7'b0000011, 8'h42, 3'd1);
        run_case("R6 plane0 d0", 16, 32'h2066, 7'b0000010, 8'h66, 3'd0);
    endtask

    task automatic t_long();
        run_case("R2 24 bits", 24, 32'h00FF_0255, 7'b0100000, 8'h55, 3'd0);
        run_case("R2 chain test", 32, 32'hABCD_0711, 7'b0000100, 8'h11, 3'd0);
        run_case("R2 R7 chain idle", 32, 32'h0302_0000, 7'b0, 8'h11, 3'd0);
    endtask

    task automatic t_short();
        run_case("R3 15 bits", 15, 32'h0102, 7'b0, 8'h11, 3'd0);
        run_case("R3 split a", 10, 32'h0000_0103, 7'b0, 8'h11, 3'd0);
        run_case("R3 split b", 10, 32'h0000_0299, 7'b0, 8'h11, 3'd0);
    endtask

    task automatic t_ignored();
        run_case("R7 idle", 16, 32'h0033, 7'b0, 8'h11, 3'd0);
        run_case("R7 reserved", 16, 32'h0644, 7'b0, 8'h11, 3'd0);
        run_case("R8 addr 05", 16, 32'h0555, 7'b0, 8'h11, 3'd0);
        run_case("R8 addr 28", 16, 32'h2877, 7'b0, 8'h11, 3'd0);
        run_case("R8 addr 80", 16, 32'h8001, 7'b0, 8'h11, 3'd0);
        chk(wr_digit == 3'd0, "R8 digit held", wr_digit, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_control();
        t_digit();
        t_long();
        t_short();
        t_ignored();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule